// File: doc/BRIEF.md
# Microcode-Sequenced 4-bit ALU Datapath

This block is a small processor-style datapath that runs one fixed transfer program on its own. Two 4-bit operands arrive on input pins. Each is placed in turn on a single shared 4-bit bus and captured into its own operand register. A 4-bit function-select ALU combines the two registers. The ALU has a mode bit, a carry input and a carry output. Its result crosses the same bus into a small word-addressed store. The stored word is then presented on an output port.

A microaddress counter steps on its own. It addresses a combinational control store, and each control store entry is a 17-bit horizontal word. That word drives every bus enable, register gate, store strobe and ALU select for one step. No hand-set control lines are needed. The store, the registers and the ALU are all 4 bits wide, so the data path has one width throughout.

The ALU operation that the program uses is fixed by a 5-bit parameter, `{mode, select}`, which the control store places in its ALU field. After step 6 the counter parks at an idle microaddress, where every enable is off. It stays there until the next reset. The host loads operands, holds reset for one clock, releases it, and reads the result during steps 5 and 6.

Top module: `mpalu_core`

## Requirements
- R1: A clock edge with `rst` high sets `useq_addr` to 0, clears `carry_out` to 0 and forces `data_oe` low and `data_out` to 0.
- R2: Each edge with `step_en` high and `rst` low advances `useq_addr` by one, from 0 up to the idle address 7, and `useq_addr` then stays at 7 until reset.
- R3: An edge with `step_en` low leaves `useq_addr` unchanged.
- R4: In every step at most one source drives the shared bus. The four bus-drive enables are control-word bits 0, 1, 7 and 8, and they are active-low.
- R5: The edge that ends step 0 captures `opnd_a` and the edge that ends step 1 captures `opnd_b`. Changes on the operand pins after those edges have no effect on the result.
- R6: With mode bit 1, the ALU gives the 16 logic functions of select S3..S0. These include 0000 = NOT A, 0110 = A XOR B, 1011 = A AND B, 1110 = A OR B and 1111 = A. The ALU carry output is 0 in this mode.
- R7: With mode bit 0, the ALU computes the 5-bit sum X + Y + `carry_in`, where X = A | (B & S0) | (~B & S1) and Y = (A & ~B & S2) | (A & B & S3). F is the low 4 bits of the sum and the carry output is bit 4. `carry_in` is active-high.
- R8: `carry_out` takes the ALU carry at the edge that ends step 2 and holds it until the next reset.
- R9: The edge that ends step 3 writes the ALU result into the store at the word selected by `mem_addr`.
- R10: `data_oe` is high only in steps 5 and 6, and there `data_out` shows the stored word at the current `mem_addr`. In every other step `data_out` is 0.
- R11: Parameter `ALU_FN` = {mode, S3..S0} selects the ALU function applied by the program. The default 5'b01001 gives A plus B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the program |
| step_en | input | 1 | Clock enable for the microaddress counter |
| opnd_a | input | 4 | First operand |
| opnd_b | input | 4 | Second operand |
| carry_in | input | 1 | ALU carry input, active-high |
| mem_addr | input | ADDR_W | Store word address for write and read |
| data_out | output | 4 | Stored word while output enabled, else 0 |
| data_oe | output | 1 | Output buffer enabled |
| carry_out | output | 1 | Registered ALU carry from step 2 |
| useq_addr | output | 4 | Current microaddress |

## Verification
At the ports, only one ALU function is ever visible: the function that `ALU_FN` fixes at build time. Covering all 32 mode and select combinations through the program would therefore need 32 separate builds. To cover them, the bench instantiates the ALU submodule on its own and sweeps every mode, select, operand pair and carry against a function table. It also builds a second top-level instance with a logic-mode function, which shows that the parameter reaches the control word. The store's address decoupling is another case that is hard to reach. To exercise it, the bench switches `mem_addr` after the write step, so that an earlier run's word must come back.

// File: rtl/mpalu_pkg.sv
package mpalu_pkg;

    localparam int DATA_W  = 4;
    localparam int UADDR_W = 4;
    localparam int CTRL_W  = 17;

    localparam logic [UADDR_W-1:0] ST_LD_A  = 4'd0;
    localparam logic [UADDR_W-1:0] ST_LD_B  = 4'd1;
    localparam logic [UADDR_W-1:0] ST_EXEC  = 4'd2;
    localparam logic [UADDR_W-1:0] ST_WRITE = 4'd3;
    localparam logic [UADDR_W-1:0] ST_SEL   = 4'd4;
    localparam logic [UADDR_W-1:0] ST_SHOW  = 4'd5;
    localparam logic [UADDR_W-1:0] ST_ECHO  = 4'd6;
    localparam logic [UADDR_W-1:0] ST_IDLE  = 4'd7;

    // horizontal control word, bit 16 first, bit 0 last
    typedef struct packed {
        logic [1:0] spare;      // 16:15
        logic       flag_ld;    // 14 capture ALU carry
        logic [3:0] sel;        // 13:10 ALU select
        logic       mode;       // 9 ALU mode
        logic       mem_drv_n;  // 8 store onto bus
        logic       alu_drv_n;  // 7 ALU onto bus
        logic       g2;         // 6 operand register B gate
        logic       g1;         // 5 operand register A gate
        logic       oe_n;       // 4 output buffer
        logic       we_n;       // 3 store write
        logic       cs_n;       // 2 store select
        logic       in2_n;      // 1 operand B onto bus
        logic       in1_n;      // 0 operand A onto bus
    } ctrl_t;

    function automatic ctrl_t ctrl_word(input logic [UADDR_W-1:0] ua,
                                        input logic [4:0] fn);
        ctrl_t w;
        w = '{spare: 2'b00, flag_ld: 1'b0, sel: fn[3:0], mode: fn[4],
              mem_drv_n: 1'b1, alu_drv_n: 1'b1, g2: 1'b0, g1: 1'b0,
              oe_n: 1'b1, we_n: 1'b1, cs_n: 1'b1, in2_n: 1'b1, in1_n: 1'b1};
        case (ua)
            ST_LD_A:  begin w.in1_n = 1'b0; w.g1 = 1'b1; end
            ST_LD_B:  begin w.in2_n = 1'b0; w.g2 = 1'b1; end
            ST_EXEC:  w.flag_ld = 1'b1;
            ST_WRITE: begin w.alu_drv_n = 1'b0; w.cs_n = 1'b0; w.we_n = 1'b0; end
            ST_SEL:   w.cs_n = 1'b0;
            ST_SHOW:  begin w.cs_n = 1'b0; w.oe_n = 1'b0; end
            ST_ECHO:  begin w.cs_n = 1'b0; w.oe_n = 1'b0; w.mem_drv_n = 1'b0; end
            default:  ;
        endcase
        return w;
    endfunction

    // returns {carry, f}
    function automatic logic [DATA_W:0] alu_eval(input logic m,
                                                 input logic [3:0] s,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic cin);
        logic [DATA_W-1:0] t1, t2;
        logic [DATA_W:0]   sum;
        t1  = a | (b & {DATA_W{s[0]}}) | (~b & {DATA_W{s[1]}});
        t2  = (a & ~b & {DATA_W{s[2]}}) | (a & b & {DATA_W{s[3]}});
        sum = {1'b0, t1} + {1'b0, t2} + {{DATA_W{1'b0}}, cin};
        return m ? {1'b0, ~(t1 ^ t2)} : sum;
    endfunction

endpackage

// File: rtl/mpalu_useq.sv
module mpalu_useq
    import mpalu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    output logic [UADDR_W-1:0] upc
);

    always_ff @(posedge clk) begin
        if (rst)
            upc <= '0;
        else if (step_en && upc != ST_IDLE)
            upc <= upc + 1'b1;
    end

    // R1
    useq_reset_chk: assert property (@(posedge clk) rst |=> (upc == '0));
    // R2
    useq_park_chk: assert property (@(posedge clk) disable iff (rst)
        (upc == ST_IDLE) |=> (upc == ST_IDLE));
    // R2
    useq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && upc < ST_IDLE) |=> (upc == $past(upc) + 1'b1));
    // R3
    useq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(upc));

endmodule

// File: rtl/mpalu_rom.sv
module mpalu_rom
    import mpalu_pkg::*;
#(
    parameter logic [4:0] ALU_FN = 5'b01001
) (
    input  logic [UADDR_W-1:0] ua,
    output ctrl_t              ctl
);

    always_comb ctl = ctrl_word(ua, ALU_FN);

endmodule

// File: rtl/mpalu_alu.sv
module mpalu_alu
    import mpalu_pkg::*;
(
    input  logic              mode,
    input  logic [3:0]        sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] f,
    output logic              cout
);

    always_comb {cout, f} = alu_eval(mode, sel, a, b, cin);

    // R6
    always_comb begin
        if (mode === 1'b1)
            alu_logic_nocarry_chk: assert (cout == 1'b0);
    end

endmodule

// File: rtl/mpalu_store.sv
module mpalu_store
    import mpalu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!cs_n && !we_n)
            mem[addr] <= wdata;
    end

    always_comb begin
        rdata = mem[addr];
        doe   = !cs_n && !oe_n;
        dout  = doe ? rdata : '0;
    end

    // R9
    store_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/mpalu_core.sv
module mpalu_core
    import mpalu_pkg::*;
#(
    parameter int         ADDR_W = 4,
    parameter logic [4:0] ALU_FN = 5'b01001
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic               carry_in,
    input  logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  data_out,
    output logic               data_oe,
    output logic               carry_out,
    output logic [UADDR_W-1:0] useq_addr
);

    ctrl_t             ctl;
    logic [DATA_W-1:0] bus, lat_a, lat_b, alu_f, mem_rd;
    logic              alu_co;
    logic              unused_spare;

    mpalu_useq u_seq (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .upc     (useq_addr)
    );

    mpalu_rom #(.ALU_FN(ALU_FN)) u_rom (
        .ua  (useq_addr),
        .ctl (ctl)
    );

    assign unused_spare = ^ctl.spare;

    // shared bus: one active-low source at a time
    always_comb begin
        if (!ctl.in1_n)          bus = opnd_a;
        else if (!ctl.in2_n)     bus = opnd_b;
        else if (!ctl.alu_drv_n) bus = alu_f;
        else if (!ctl.mem_drv_n) bus = mem_rd;
        else                     bus = '0;
    end

    // operand registers follow the bus while gated, hold otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_a <= '0;
            lat_b <= '0;
        end else begin
            if (ctl.g1) lat_a <= bus;
            if (ctl.g2) lat_b <= bus;
        end
    end

    mpalu_alu u_alu (
        .mode (ctl.mode),
        .sel  (ctl.sel),
        .a    (lat_a),
        .b    (lat_b),
        .cin  (carry_in),
        .f    (alu_f),
        .cout (alu_co)
    );

    always_ff @(posedge clk) begin
        if (rst)              carry_out <= 1'b0;
        else if (ctl.flag_ld) carry_out <= alu_co;
    end

    mpalu_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (ctl.cs_n),
        .we_n  (ctl.we_n),
        .oe_n  (ctl.oe_n),
        .addr  (mem_addr),
        .wdata (bus),
        .rdata (mem_rd),
        .dout  (data_out),
        .doe   (data_oe)
    );

    // R4
    bus_one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({~ctl.in1_n, ~ctl.in2_n, ~ctl.alu_drv_n, ~ctl.mem_drv_n}) <= 1);
    // R5
    opnd_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.g1 |=> $stable(lat_a));
    // R8
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.flag_ld |=> $stable(carry_out));
    // R10
    out_window_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (useq_addr == ST_SHOW || useq_addr == ST_ECHO));

endmodule

// File: tb/mpalu_core_test.sv
module mpalu_core_test;
    import mpalu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [3:0] a = '0, b = '0, ma = '0;
    logic       cin = 1'b0;
    logic [3:0] dout_p, dout_x, upc_p, upc_x;
    logic       doe_p, doe_x, co_p, co_x;

    logic       sm, sc, sco;
    logic [3:0] ss, sa, sb, sf;

    logic [3:0] mem_p [16];
    logic [3:0] mem_x [16];
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mpalu_core uut (.clk(clk), .rst(rst), .step_en(step_en), .opnd_a(a), .opnd_b(b),
        .carry_in(cin), .mem_addr(ma), .data_out(dout_p), .data_oe(doe_p),
        .carry_out(co_p), .useq_addr(upc_p));

    mpalu_core #(.ALU_FN(5'b10110)) uut_xor (.clk(clk), .rst(rst), .step_en(step_en),
        .opnd_a(a), .opnd_b(b), .carry_in(cin), .mem_addr(ma), .data_out(dout_x),
        .data_oe(doe_x), .carry_out(co_x), .useq_addr(upc_x));

    mpalu_alu alu_sweep (.mode(sm), .sel(ss), .a(sa), .b(sb), .cin(sc), .f(sf), .cout(sco));

    function automatic logic [4:0] ref_alu(input logic m, input logic [3:0] s,
                                           input logic [3:0] x, input logic [3:0] y,
                                           input logic c);
        logic [4:0] r;
        logic [4:0] xa, xb, nb, ci;
        xa = {1'b0, x}; xb = {1'b0, y}; nb = {1'b0, ~y}; ci = {4'b0, c};
        if (m) begin
            case (s)
                4'h0: r = {1'b0, ~x};
                4'h1: r = {1'b0, ~(x | y)};
                4'h2: r = {1'b0, ~x & y};
                4'h3: r = 5'h00;
                4'h4: r = {1'b0, ~(x & y)};
                4'h5: r = {1'b0, ~y};
                4'h6: r = {1'b0, x ^ y};
                4'h7: r = {1'b0, x & ~y};
                4'h8: r = {1'b0, ~x | y};
                4'h9: r = {1'b0, ~(x ^ y)};
                4'hA: r = {1'b0, y};
                4'hB: r = {1'b0, x & y};
                4'hC: r = 5'h0F;
                4'hD: r = {1'b0, x | ~y};
                4'hE: r = {1'b0, x | y};
                default: r = {1'b0, x};
            endcase
        end else begin
            case (s)
                4'h0: r = xa + ci;
                4'h1: r = (xa | xb) + ci;
                4'h2: r = (xa | nb) + ci;
                4'h3: r = 5'h0F + ci;
                4'h4: r = xa + (xa & nb) + ci;
                4'h5: r = (xa | xb) + (xa & nb) + ci;
                4'h6: r = xa + nb + ci;
                4'h7: r = (xa & nb) + 5'h0F + ci;
                4'h8: r = xa + (xa & xb) + ci;
                4'h9: r = xa + xb + ci;
                4'hA: r = (xa | nb) + (xa & xb) + ci;
                4'hB: r = (xa & xb) + 5'h0F + ci;
                4'hC: r = xa + xa + ci;
                4'hD: r = (xa | xb) + xa + ci;
                4'hE: r = (xa | nb) + xa + ci;
                default: r = 5'h0F + xa + ci;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_seq(input logic [3:0] va, input logic [3:0] vb, input logic vc,
                           input logic [3:0] wa, input logic [3:0] ra, input int stall);
        logic [4:0] ep, ex;
        ep = ref_alu(1'b0, 4'b1001, va, vb, vc);
        ex = ref_alu(1'b1, 4'b0110, va, vb, vc);
        a = va; b = vb; cin = vc; ma = wa; step_en = 1'b1;
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 useq_addr after reset", 8'(upc_p), 8'd0);
        chk("R1 data_oe after reset", 8'(doe_p), 8'd0);
        chk("R1 carry_out after reset", 8'(co_p), 8'd0);
        @(negedge clk);
        chk("R2 step 1", 8'(upc_p), 8'd1);
        @(negedge clk);
        a = 4'($urandom); b = 4'($urandom);   // R5: late operand changes
        if (stall > 0) begin
            step_en = 1'b0;
            repeat (stall) @(negedge clk);
            chk("R3 stalled useq_addr", 8'(upc_p), 8'd2);
            step_en = 1'b1;
        end
        @(negedge clk);
        chk("R8 carry_out add", 8'(co_p), 8'(ep[4]));
        chk("R6 carry_out logic mode", 8'(co_x), 8'd0);
        chk("R10 data_oe off in step 3", 8'(doe_p), 8'd0);
        @(negedge clk);
        mem_p[wa] = ep[3:0];
        mem_x[wa] = ex[3:0];
        ma = ra;
        chk("R10 data_out zero in step 4", 8'(dout_p), 8'd0);
        @(negedge clk);
        chk("R10 data_oe step 5", 8'(doe_p), 8'd1);
        chk("R5 R9 R10 result step 5", 8'(dout_p), 8'(mem_p[ra]));
        chk("R11 xor result step 5", 8'(dout_x), 8'(mem_x[ra]));
        cin = ~cin;
        @(negedge clk);
        chk("R10 result step 6", 8'(dout_p), 8'(mem_p[ra]));
        chk("R8 carry_out held", 8'(co_p), 8'(ep[4]));
        @(negedge clk);
        chk("R10 data_oe off at idle", 8'(doe_p), 8'd0);
        chk("R10 data_out zero at idle", 8'(dout_p), 8'd0);
        repeat (3) @(negedge clk);
        chk("R2 parked at idle", 8'(upc_p), 8'd7);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        // ALU sweep over every mode, select, operand pair and carry
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 16; s++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++)
                        for (int c = 0; c < 2; c++) begin
                            logic [4:0] e;
                            sm = 1'(m); ss = 4'(s); sa = 4'(x); sb = 4'(y); sc = 1'(c);
                            #1;
                            e = ref_alu(sm, ss, sa, sb, sc);
                            chk(m ? "R6 alu logic" : "R7 alu arith", {3'b0, sco, sf}, {3'b0, e});
                        end
        // directed corners
        run_seq(4'hF, 4'h1, 1'b0, 4'd3, 4'd3, 0);   // carry out of A+B
        run_seq(4'h0, 4'h0, 1'b1, 4'd5, 4'd3, 2);   // read earlier word, stall
        run_seq(4'hF, 4'hF, 1'b1, 4'd15, 4'd15, 1);
        run_seq(4'h0, 4'h0, 1'b0, 4'd0, 4'd5, 0);
        // random runs
        for (int i = 0; i < 30; i++) begin
            logic [3:0] w;
            w = 4'($urandom);
            run_seq(4'($urandom), 4'($urandom), 1'($urandom), w, w, int'($urandom % 3));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule